// File: doc/BRIEF.md
# Cached DRAM Refresh and Start-Up Sequencer

This block sits on the host side of a cached DRAM and owns the control strobes whenever the normal access controller does not. After reset it keeps row-enable high for a settling window. It then runs the start-up sequence: eight internal-refresh cycles followed by two read cycles to two different rows. Only after that does it raise a done flag and begin handing the bus to the access controller.

In normal operation a free-running interval counter sets a pending-refresh flag once every `REF_INTERVAL` clock cycles. The pending refresh is issued at the next point where the bus is idle. An access that already holds the grant is never cut short. The access controller asks for the bus with a level request and keeps it for as long as the request stays high. During a granted access the sequencer holds its own strobes at their inactive levels.

A self-refresh request puts the device into self-refresh with the required strobe combination. On release the sequencer holds row-enable high for a recovery window and then issues one internal refresh at once. Every time constant is a parameter counted in clock cycles.

Top module: `cdram_refresh_seq`

## Requirements
- R1: While reset is active and on the first cycles after it, all strobe outputs are high (row-enable, refresh-select, write/read, column-latch, write-enable, chip-select and output-enable), `addr_o` is 0, and grant, done and self-refresh-active are low.
- R2: After reset, row-enable stays high for at least `T_PWRUP` cycles before its first falling edge.
- R3: The first eight row-enable activations are internal refreshes, meaning refresh-select is low at the falling edge. The ninth and tenth are reads: refresh-select high, chip-select low and write/read low at the falling edge. The ninth read drives row 0 on `addr_o` and the tenth drives row 1.
- R4: `init_done_o` rises only after all ten start-up activations. `acc_gnt_o` is never high while `init_done_o` is low.
- R5: Between two start-up refreshes, row-enable stays high for at least `T_RP_B2B` cycles. After any other refresh or read, it stays high for at least `T_RP` cycles before the next activation.
- R6: An internal refresh lowers refresh-select at least one cycle before row-enable falls. It holds column-latch and write-enable high and keeps row-enable low for exactly `T_RAS` cycles. Reads also hold row-enable low for exactly `T_RAS` cycles.
- R7: With the bus idle, internal refreshes after start-up begin on a fixed schedule of exactly `REF_INTERVAL` cycles.
- R8: A request seen while the bus is idle and no refresh is pending is granted. Row-enable never falls while `acc_gnt_o` is high. A refresh that became pending during a grant starts within five cycles of the request being dropped.
- R9: Self-refresh is entered with chip-select, write/read, refresh-select and write-enable high and column-latch low at the falling edge of row-enable. `sr_active_o` is high exactly while that state holds.
- R10: Row-enable stays low for as long as `sr_req_i` is held. After release, row-enable stays high for exactly `T_RP_SR + 1` cycles: the recovery window plus one setup cycle. The next activation is an internal refresh.
- R11: Row-enable falls with chip-select high only for internal refresh and self-refresh, never for a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_req_i | input | 1 | Bus request from the access controller (level) |
| acc_gnt_o | output | 1 | Bus granted to the access controller |
| sr_req_i | input | 1 | Self-refresh request (level) |
| sr_active_o | output | 1 | Device held in self-refresh |
| init_done_o | output | 1 | Start-up sequence complete |
| row_en_no | output | 1 | Row-enable strobe, active low |
| ref_sel_no | output | 1 | Internal-refresh select, active low |
| wr_rd_o | output | 1 | Write (1) / read (0) select |
| col_lat_no | output | 1 | Column-address latch strobe, active low |
| wr_en_no | output | 1 | Write-enable, active low |
| chip_sel_no | output | 1 | Chip-select, active low |
| out_en_no | output | 1 | Output-enable, active low |
| addr_o | output | ROW_W | Row address for the start-up reads |

## Verification
Start-up is run with the access request held high from reset. This separates a correct gate on the grant from a premature one, and it also checks the order of refreshes and reads and the two distinct rows. A long idle window checks the exact refresh spacing. A grant held across a full refresh interval shows that a refresh is deferred and not forced into the access, and that it follows promptly after release. Directed and random self-refresh requests, mixed with random access bursts of random length and gap, exercise the entry levels, the hold-while-requested behaviour and the exact recovery-then-refresh exit in every phase of the refresh schedule.

// File: rtl/cdram_seq_pkg.sv
package cdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_REF_SU,
    ST_REF_ACT,
    ST_RD_SU,
    ST_RD_ACT,
    ST_PRE,
    ST_IDLE,
    ST_GNT,
    ST_SR_SU,
    ST_SR_ACT,
    ST_SR_REC
  } seq_state_e;

  typedef struct packed {
    logic row_en_n;
    logic ref_sel_n;
    logic wr_rd;
    logic col_lat_n;
    logic wr_en_n;
    logic chip_sel_n;
    logic out_en_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = strobe_t'(7'h7F);

endpackage

// File: rtl/cdram_seq_timer.sv
module cdram_seq_timer #(
  parameter int          W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R5

endmodule

// File: rtl/cdram_ref_interval.sv
module cdram_ref_interval #(
  parameter int unsigned INTERVAL = 7800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic pending_o
);

  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          wrap;

  assign wrap = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // a new interval expiry wins over a simultaneous take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (wrap)    pend_q <= 1'b1;
    else if (take_i)  pend_q <= 1'b0;
  end

  assign pending_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q); // R7
  AST_NO_PEND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pend_q); // R7

endmodule

// File: rtl/cdram_seq_fsm.sv
module cdram_seq_fsm
  import cdram_seq_pkg::*;
#(
  parameter int TW         = 8,
  parameter int ROW_W      = 11,
  parameter int T_RAS      = 4,
  parameter int T_RP       = 4,
  parameter int T_RP_B2B   = 5,
  parameter int T_RP_SR    = 13,
  parameter int INIT_REFS  = 8,
  parameter int INIT_READS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_req_i,
  input  logic             sr_req_i,
  input  logic             pending_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TW-1:0]    tmr_val_o,
  output logic             take_o,
  output logic             done_o,
  output seq_state_e       state_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int RFW = $clog2(INIT_REFS + 1);
  localparam int RDW = $clog2(INIT_READS + 1);
  localparam logic [RFW-1:0] REFS_ALL  = RFW'(INIT_REFS);
  localparam logic [RFW-1:0] REFS_LAST = RFW'(INIT_REFS - 1);
  localparam logic [RDW-1:0] READS_ALL = RDW'(INIT_READS);

  seq_state_e     state_q, state_d;
  logic [RFW-1:0] ref_cnt_q;
  logic [RDW-1:0] rd_cnt_q;
  logic           done_q;
  logic           set_done, inc_ref, inc_rd;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    take_o     = 1'b0;
    set_done   = 1'b0;
    inc_ref    = 1'b0;
    inc_rd     = 1'b0;
    case (state_q)
      ST_PWRUP: if (tmr_zero_i) state_d = ST_REF_SU;
      ST_REF_SU: begin
        state_d    = ST_REF_ACT;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RAS - 1);
      end
      ST_REF_ACT: if (tmr_zero_i) begin
        state_d    = ST_PRE;
        tmr_load_o = 1'b1;
        inc_ref    = !done_q;
        // another start-up refresh follows: longer precharge
        tmr_val_o  = (!done_q && ref_cnt_q < REFS_LAST) ? TW'(T_RP_B2B - 1)
                                                        : TW'(T_RP - 1);
      end
      ST_RD_SU: begin
        state_d    = ST_RD_ACT;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RAS - 1);
      end
      ST_RD_ACT: if (tmr_zero_i) begin
        state_d    = ST_PRE;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RP - 1);
        inc_rd     = 1'b1;
      end
      ST_PRE: if (tmr_zero_i) begin
        if (done_q)                   state_d = ST_IDLE;
        else if (ref_cnt_q < REFS_ALL) state_d = ST_REF_SU;
        else if (rd_cnt_q < READS_ALL) state_d = ST_RD_SU;
        else begin
          set_done = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (pending_i) begin
          take_o  = 1'b1;
          state_d = ST_REF_SU;
        end else if (sr_req_i) begin
          state_d = ST_SR_SU;
        end else if (acc_req_i) begin
          state_d = ST_GNT;
        end
      end
      ST_GNT:    if (!acc_req_i) state_d = ST_IDLE;
      ST_SR_SU:  state_d = ST_SR_ACT;
      ST_SR_ACT: if (!sr_req_i) begin
        state_d    = ST_SR_REC;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(T_RP_SR - 1);
      end
      ST_SR_REC: if (tmr_zero_i) begin
        take_o  = 1'b1;
        state_d = ST_REF_SU;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PWRUP;
      ref_cnt_q <= '0;
      rd_cnt_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (inc_ref)  ref_cnt_q <= ref_cnt_q + 1'b1;
      if (inc_rd)   rd_cnt_q  <= rd_cnt_q + 1'b1;
      if (set_done) done_q    <= 1'b1;
    end
  end

  assign done_o  = done_q;
  assign state_o = state_q;
  assign row_o   = ROW_W'(rd_cnt_q);

  AST_NO_GNT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GNT) |-> done_q); // R4
  AST_READS_AFTER_REFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_SU) |-> (ref_cnt_q == REFS_ALL)); // R3
  AST_REF_FROM_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REF_ACT && $past(state_q) != ST_REF_ACT) |-> ($past(state_q) == ST_REF_SU)); // R6

endmodule

// File: rtl/cdram_seq_drive.sv
module cdram_seq_drive
  import cdram_seq_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_state_e       state_i,
  input  logic [ROW_W-1:0] row_i,
  output strobe_t          strobe_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             gnt_o,
  output logic             sr_active_o
);

  strobe_t          strobe_d, strobe_q;
  logic [ROW_W-1:0] addr_d, addr_q;
  logic             gnt_q, sr_active_q;

  always_comb begin
    strobe_d = STROBE_IDLE;
    addr_d   = '0;
    case (state_i)
      ST_REF_SU:  strobe_d.ref_sel_n = 1'b0;
      ST_REF_ACT: begin
        strobe_d.ref_sel_n = 1'b0;
        strobe_d.row_en_n  = 1'b0;
      end
      ST_RD_SU: begin
        strobe_d.chip_sel_n = 1'b0;
        strobe_d.wr_rd      = 1'b0;
        addr_d              = row_i;
      end
      ST_RD_ACT: begin
        strobe_d.chip_sel_n = 1'b0;
        strobe_d.wr_rd      = 1'b0;
        strobe_d.row_en_n   = 1'b0;
        strobe_d.out_en_n   = 1'b0;
        addr_d              = row_i;
      end
      ST_SR_SU:   strobe_d.col_lat_n = 1'b0;
      ST_SR_ACT: begin
        strobe_d.col_lat_n = 1'b0;
        strobe_d.row_en_n  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q    <= STROBE_IDLE;
      addr_q      <= '0;
      gnt_q       <= 1'b0;
      sr_active_q <= 1'b0;
    end else begin
      strobe_q    <= strobe_d;
      addr_q      <= addr_d;
      gnt_q       <= (state_i == ST_GNT);
      sr_active_q <= (state_i == ST_SR_ACT);
    end
  end

  assign strobe_o    = strobe_q;
  assign addr_o      = addr_q;
  assign gnt_o       = gnt_q;
  assign sr_active_o = sr_active_q;

  AST_CS_OFF_REF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(strobe_q.row_en_n) && strobe_q.chip_sel_n) |-> (!strobe_q.ref_sel_n || !strobe_q.col_lat_n)); // R11
  AST_SR_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_active_q |-> (!strobe_q.row_en_n && strobe_q.chip_sel_n && strobe_q.wr_rd &&
                     strobe_q.ref_sel_n && strobe_q.wr_en_n && !strobe_q.col_lat_n)); // R9
  AST_GNT_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q |-> (strobe_q.row_en_n && strobe_q.chip_sel_n)); // R8
  AST_REF_SEL_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(strobe_q.row_en_n) && !strobe_q.ref_sel_n) |-> !$past(strobe_q.ref_sel_n)); // R6

endmodule

// File: rtl/cdram_refresh_seq.sv
module cdram_refresh_seq
  import cdram_seq_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int T_PWRUP      = 40,
  parameter int T_RAS        = 4,
  parameter int T_RP         = 4,
  parameter int T_RP_B2B     = 5,
  parameter int T_RP_SR      = 13,
  parameter int REF_INTERVAL = 7800,
  parameter int INIT_REFS    = 8,
  parameter int INIT_READS   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_req_i,
  output logic             acc_gnt_o,
  input  logic             sr_req_i,
  output logic             sr_active_o,
  output logic             init_done_o,
  output logic             row_en_no,
  output logic             ref_sel_no,
  output logic             wr_rd_o,
  output logic             col_lat_no,
  output logic             wr_en_no,
  output logic             chip_sel_no,
  output logic             out_en_no,
  output logic [ROW_W-1:0] addr_o
);

  localparam int TW = $clog2(T_PWRUP + T_RP_SR + T_RAS + T_RP + T_RP_B2B + 1);

  seq_state_e       state;
  strobe_t          strobe;
  logic             tmr_load, tmr_zero, take, pending, done;
  logic [TW-1:0]    tmr_val;
  logic [ROW_W-1:0] init_row;

  cdram_seq_timer #(
    .W       (TW),
    .RST_VAL (T_PWRUP - 1)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cdram_ref_interval #(
    .INTERVAL (REF_INTERVAL)
  ) u_interval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (done),
    .take_i    (take),
    .pending_o (pending)
  );

  cdram_seq_fsm #(
    .TW         (TW),
    .ROW_W      (ROW_W),
    .T_RAS      (T_RAS),
    .T_RP       (T_RP),
    .T_RP_B2B   (T_RP_B2B),
    .T_RP_SR    (T_RP_SR),
    .INIT_REFS  (INIT_REFS),
    .INIT_READS (INIT_READS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_req_i  (acc_req_i),
    .sr_req_i   (sr_req_i),
    .pending_i  (pending),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .take_o     (take),
    .done_o     (done),
    .state_o    (state),
    .row_o      (init_row)
  );

  cdram_seq_drive #(
    .ROW_W (ROW_W)
  ) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .row_i       (init_row),
    .strobe_o    (strobe),
    .addr_o      (addr_o),
    .gnt_o       (acc_gnt_o),
    .sr_active_o (sr_active_o)
  );

  assign init_done_o = done;
  assign row_en_no   = strobe.row_en_n;
  assign ref_sel_no  = strobe.ref_sel_n;
  assign wr_rd_o     = strobe.wr_rd;
  assign col_lat_no  = strobe.col_lat_n;
  assign wr_en_no    = strobe.wr_en_n;
  assign chip_sel_no = strobe.chip_sel_n;
  assign out_en_no   = strobe.out_en_n;

endmodule

// File: tb/cdram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module cdram_refresh_seq_tb_top;

  localparam int ROW_W    = 11;
  localparam int T_PWRUP  = 38;
  localparam int T_RAS    = 4;
  localparam int T_RP     = 3;
  localparam int T_RP_B2B = 5;
  localparam int T_RP_SR  = 13;
  localparam int REF_INT  = 300;

  localparam int K_REF = 0;
  localparam int K_RD  = 1;
  localparam int K_SR  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_req_i = 1'b0;
  logic sr_req_i = 1'b0;
  logic acc_gnt_o, sr_active_o, init_done_o;
  logic row_en_no, ref_sel_no, wr_rd_o, col_lat_no, wr_en_no, chip_sel_no, out_en_no;
  logic [ROW_W-1:0] addr_o;

  always #4 clk = ~clk;

  cdram_refresh_seq #(
    .ROW_W        (ROW_W),
    .T_PWRUP      (T_PWRUP),
    .T_RAS        (T_RAS),
    .T_RP         (T_RP),
    .T_RP_B2B     (T_RP_B2B),
    .T_RP_SR      (T_RP_SR),
    .REF_INTERVAL (REF_INT),
    .INIT_REFS    (8),
    .INIT_READS   (2)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .acc_req_i   (acc_req_i),
    .acc_gnt_o   (acc_gnt_o),
    .sr_req_i    (sr_req_i),
    .sr_active_o (sr_active_o),
    .init_done_o (init_done_o),
    .row_en_no   (row_en_no),
    .ref_sel_no  (ref_sel_no),
    .wr_rd_o     (wr_rd_o),
    .col_lat_no  (col_lat_no),
    .wr_en_no    (wr_en_no),
    .chip_sel_no (chip_sel_no),
    .out_en_no   (out_en_no),
    .addr_o      (addr_o)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // expected minimum precharge before the next activation
  function automatic int min_pre(input int kind, input int idx);
    if (kind == K_REF && idx >= 1 && idx <= 7) return T_RP_B2B;
    return T_RP;
  endfunction

  // ---------------- monitor ----------------
  int  cyc = 0, act_idx = 0, hi_len = 0, lo_len = 0, last_kind = -1;
  int  early_gnt = 0, early_done = 0, phase = -1, n_r7 = 0;
  bit  prev_row = 1'b1, quiet = 1'b0, prev_quiet = 1'b0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_row = 1'b1; hi_len = 0; lo_len = 0;
    end else begin
      int kind;
      cyc++;
      if (acc_gnt_o && !init_done_o) early_gnt++;
      if (init_done_o && act_idx < 10) early_done++;
      if (acc_req_i || acc_gnt_o || sr_req_i || sr_active_o) quiet = 1'b0;
      if (prev_row && !row_en_no) begin
        if (!ref_sel_no)      kind = K_REF;
        else if (!col_lat_no) kind = K_SR;
        else                  kind = K_RD;
        if (act_idx == 0)
          chk(hi_len >= T_PWRUP, "R2 power-up high time", hi_len, T_PWRUP);
        else if (last_kind == K_SR)
          chk(kind == K_REF && hi_len == T_RP_SR + 1, "R10 exit recovery then refresh", hi_len, T_RP_SR + 1);
        else
          chk(hi_len >= min_pre(last_kind, act_idx), "R5 precharge", hi_len, min_pre(last_kind, act_idx));
        if (act_idx < 8)
          chk(kind == K_REF, "R3 start-up refresh", kind, K_REF);
        else if (act_idx < 10)
          chk(kind == K_RD && !chip_sel_no && !wr_rd_o && int'(addr_o) == act_idx - 8,
              "R3 start-up read row", int'(addr_o), act_idx - 8);
        if (kind == K_RD)
          chk(!chip_sel_no, "R11 read with chip-select active", chip_sel_no, 0);
        if (kind == K_REF)
          chk(col_lat_no && wr_en_no, "R6 refresh strobe levels", {col_lat_no, wr_en_no}, 3);
        if (kind == K_SR)
          chk(chip_sel_no && wr_rd_o && ref_sel_no && wr_en_no && !col_lat_no,
              "R9 self-refresh entry levels",
              {chip_sel_no, wr_rd_o, ref_sel_no, wr_en_no, col_lat_no}, 5'b11110);
        chk(!acc_gnt_o, "R8 no activation during grant", acc_gnt_o, 0);
        if (kind == K_REF && init_done_o) begin
          if (quiet && prev_quiet) begin
            if (phase < 0) phase = cyc % REF_INT;
            else begin
              n_r7++;
              chk(cyc % REF_INT == phase, "R7 refresh spacing", cyc % REF_INT, phase);
            end
          end
          prev_quiet = quiet;
          quiet = 1'b1;
        end
        act_idx++;
        last_kind = kind;
      end
      if (!prev_row && row_en_no && last_kind != K_SR)
        chk(lo_len == T_RAS, "R6 activation low time", lo_len, T_RAS);
      if (row_en_no) hi_len = prev_row ? hi_len + 1 : 1;
      else           lo_len = prev_row ? 1 : lo_len + 1;
      prev_row = row_en_no;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  // ---------------- stimulus ----------------
  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access_burst(input int len);
    int w;
    acc_req_i = 1'b1;
    w = 0;
    while (!acc_gnt_o && w < 60) begin @(negedge clk); w++; end
    chk(acc_gnt_o, "R8 grant latency", w, 60);
    wait_neg(len);
    acc_req_i = 1'b0;
    w = 0;
    while (acc_gnt_o && w < 10) begin @(negedge clk); w++; end
  endtask

  task automatic self_refresh(input int hold);
    int w, bad;
    sr_req_i = 1'b1;
    w = 0;
    while (!sr_active_o && w < 60) begin @(negedge clk); w++; end
    chk(sr_active_o, "R9 self-refresh entered", w, 60);
    bad = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (row_en_no || !sr_active_o) bad++;
    end
    chk(bad == 0, "R10 row-enable low while held", bad, 0);
    sr_req_i = 1'b0;
    wait_neg(T_RP_SR + 12);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd20250611));
    wait_neg(2);
    chk(row_en_no && ref_sel_no && wr_rd_o && col_lat_no && wr_en_no && chip_sel_no && out_en_no,
        "R1 strobes idle in reset",
        {row_en_no, ref_sel_no, wr_rd_o, col_lat_no, wr_en_no, chip_sel_no, out_en_no}, 7'h7F);
    chk(!acc_gnt_o && !init_done_o && !sr_active_o, "R1 flags low in reset",
        {acc_gnt_o, init_done_o, sr_active_o}, 0);
    chk(addr_o == '0, "R1 address zero", int'(addr_o), 0);
    rst_ni = 1'b1;
    acc_req_i = 1'b1;
    wait_neg(3);
    chk(row_en_no && chip_sel_no && !acc_gnt_o && !init_done_o, "R1 idle after reset",
        {row_en_no, chip_sel_no, acc_gnt_o, init_done_o}, 4'b1100);

    lat = 0;
    while (!init_done_o && lat < 2000) begin @(negedge clk); lat++; end
    chk(init_done_o, "R4 done raised", init_done_o, 1);
    chk(act_idx == 10, "R4 ten start-up activations", act_idx, 10);
    lat = 0;
    while (!acc_gnt_o && lat < 20) begin @(negedge clk); lat++; end
    chk(acc_gnt_o, "R8 grant after start-up", lat, 20);
    wait_neg(10);
    acc_req_i = 1'b0;

    wait_neg(6 * REF_INT);
    chk(n_r7 >= 2, "R7 spacing observed", n_r7, 2);

    // grant held across a whole interval: refresh deferred, then prompt
    acc_req_i = 1'b1;
    lat = 0;
    while (!acc_gnt_o && lat < 60) begin @(negedge clk); lat++; end
    wait_neg(REF_INT + 20);
    acc_req_i = 1'b0;
    lat = 0;
    while (row_en_no && lat < 20) begin @(negedge clk); lat++; end
    chk(!row_en_no && !ref_sel_no && lat <= 5, "R8 deferred refresh after release", lat, 5);

    self_refresh(25);
    self_refresh(3);

    for (int op = 0; op < 60; op++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6)      access_burst($urandom_range(1, 60));
      else if (sel < 8) self_refresh($urandom_range(2, 50));
      else              wait_neg($urandom_range(0, 40));
      wait_neg($urandom_range(0, 20));
    end
    wait_neg(2 * REF_INT);

    chk(early_gnt == 0, "R4 no grant before done", early_gnt, 0);
    chk(early_done == 0, "R4 done not before ten activations", early_done, 0);
    finish_run();
  end

endmodule